// File: doc/BRIEF.md
# Dual-Width ALU with Result Pair

This block is the arithmetic and logic unit for a 32-bit datapath that can also work on 64-bit values. In narrow mode it takes two 32-bit operands and produces one 32-bit result. In wide mode it takes two 64-bit operands, each assembled by the caller from a pair of registers, and writes its 64-bit result to a low/high output pair. Narrow mode also has long operations that write to the pair. A long multiply of two 32-bit operands gives the full 64-bit product. A long divide gives the quotient and the remainder side by side.

A 6-bit function code selects the operation, a one-bit select chooses the width, and a 10-bit shift field supplies the shift distance. Every accepted operation is registered, so the result appears one clock after it is presented. The narrow result register and the pair registers are separate. Each keeps its value until an operation that targets it comes along. The caller therefore reads the pair with a separate move, at any later time. Operand fetch and divide-by-zero traps are left to the surrounding pipeline. Division by zero returns a fixed pattern and never stalls.

Top module: `dwalu`

## Requirements
- R1: After reset, out_valid and out_pair are 0, and res_narrow, res_lo and res_hi are all zero.
- R2: In narrow mode, codes 0 and 1 (add) and codes 2 and 3 (a minus b) give the 32-bit wrapped result on res_narrow one clock later, with out_valid=1 and out_pair=0. The signed and unsigned variants give identical bits, and res_lo and res_hi keep their values.
- R3: In narrow mode, codes 4 and 5 give the low 32 bits of the product. Code 6 gives the signed quotient, truncated toward zero. Code 7 gives the unsigned quotient.
- R4: In narrow mode, codes 8 to 13 give a&b, a|b, ~(a&b), ~(a|b), a^b and ~(a^b), in that order.
- R5: In narrow mode, code 24 shifts left logically, code 25 shifts right logically and code 26 shifts right arithmetically, filling with bit 31. The distance is shamt[4:0], and shamt[9:5] has no effect.
- R6: In narrow mode, code 16 (signed) and code 17 (unsigned) form the full 64-bit product. Bits 31:0 go to res_lo, bits 63:32 go to res_hi, out_pair=1, and res_narrow keeps its value.
- R7: In narrow mode, code 18 (signed) and code 19 (unsigned) put the quotient in res_lo and the remainder in res_hi. A signed remainder takes the sign of the dividend.
- R8: In wide mode, codes 0 to 13 apply the same operations to the 64-bit operands. Bits 31:0 of the result go to res_lo and bits 63:32 go to res_hi, with out_pair=1. A multiply keeps the low 64 bits of the product, and res_narrow keeps its value.
- R9: In wide mode, codes 24, 25 and 26 shift a_wide by shamt[5:0], and shamt[9:6] has no effect. The arithmetic right shift fills with bit 63.
- R10: A divisor of zero, at either width and for either signedness, gives an all-ones quotient. Where a remainder is produced, it equals the dividend.
- R11: A signed divide of the most negative value by minus one gives that most negative value as the quotient and zero as the remainder.
- R12: When op_valid is 0, or when the code is undefined for the selected width, out_valid is 0 one clock later and all three results hold. Codes 16 to 19 are undefined in wide mode.
- R13: out_pair is 1 exactly when the operation accepted on the previous clock wrote the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| wide_sel | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit operands |
| func | input | 6 | Function code |
| a_narrow | input | DW | First 32-bit operand |
| b_narrow | input | DW | Second 32-bit operand |
| a_wide | input | 2*DW | First 64-bit operand (register pair, low word in bits 31:0) |
| b_wide | input | 2*DW | Second 64-bit operand |
| shamt | input | SAW | Shift distance field |
| out_valid | output | 1 | A result was written on the last clock |
| out_pair | output | 1 | That result went to the low/high pair |
| res_narrow | output | DW | Narrow result register |
| res_lo | output | DW | Low half of the result pair |
| res_hi | output | DW | High half of the result pair |

## Verification
All state in this block is the three result registers and two flags, so any internal fault shows at the ports on the very next clock. A wrong sign extension, divider fix-up or shift fill corrupts the value of that one operation. A wrong write enable shows up differently: the register that should have held changes, or the flag pattern is wrong. The bench therefore compares all five outputs after every operation, including idle and undefined codes. It sweeps operand corner values across every code at both widths, so a fault shows within a few operations of the sweep.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

  typedef enum logic [3:0] {
    G_NONE, G_ADD, G_SUB, G_MUL, G_DIV, G_LOGIC, G_SHIFT, G_LMUL, G_LDIV
  } grp_e;

  // Map a function code to its operation group for the selected width.
  function automatic grp_e decode(input logic [5:0] f, input logic wide);
    grp_e g;
    case (f) inside
      6'd0, 6'd1:   g = G_ADD;
      6'd2, 6'd3:   g = G_SUB;
      6'd4, 6'd5:   g = G_MUL;
      6'd6, 6'd7:   g = G_DIV;
      [6'd8:6'd13]: g = G_LOGIC;
      [6'd24:6'd26]: g = G_SHIFT;
      6'd16, 6'd17: g = wide ? G_NONE : G_LMUL;
      6'd18, 6'd19: g = wide ? G_NONE : G_LDIV;
      default:      g = G_NONE;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/dwalu_bitops.sv
module dwalu_bitops #(
  parameter int W = 32
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] r
);
  always_comb begin
    case (sel)
      3'd0:    r = x & y;
      3'd1:    r = x | y;
      3'd2:    r = ~(x & y);
      3'd3:    r = ~(x | y);
      3'd4:    r = x ^ y;
      3'd5:    r = ~(x ^ y);
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/dwalu_shifter.sv
module dwalu_shifter #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic [1:0]    kind,
  input  logic [W-1:0]  x,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  r
);
  logic signed [W-1:0] sx;
  assign sx = x;

  always_comb begin
    case (kind)
      2'd0:    r = x << amt;
      2'd1:    r = x >> amt;
      2'd2:    r = sx >>> amt;
      default: r = x;
    endcase
  end
endmodule

// File: rtl/dwalu_divider.sv
module dwalu_divider #(
  parameter int W = 32
) (
  input  logic         sgn,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic         neg_n, neg_d;
  logic [W-1:0] mag_n, mag_d, uq, ur;

  // Divide magnitudes, then restore signs; quotient rounds toward zero.
  always_comb begin
    neg_n = sgn & num[W-1];
    neg_d = sgn & den[W-1];
    mag_n = neg_n ? -num : num;
    mag_d = neg_d ? -den : den;
    if (den == '0) begin
      uq  = '0;
      ur  = '0;
      quo = '1;
      rem = num;
    end else begin
      uq  = mag_n / mag_d;
      ur  = mag_n % mag_d;
      quo = (neg_n ^ neg_d) ? -uq : uq;
      rem = neg_n ? -ur : ur;
    end
  end
endmodule

// File: rtl/dwalu.sv
module dwalu #(
  parameter int DW  = 32,
  parameter int SAW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic            wide_sel,
  input  logic [5:0]      func,
  input  logic [DW-1:0]   a_narrow,
  input  logic [DW-1:0]   b_narrow,
  input  logic [2*DW-1:0] a_wide,
  input  logic [2*DW-1:0] b_wide,
  input  logic [SAW-1:0]  shamt,
  output logic            out_valid,
  output logic            out_pair,
  output logic [DW-1:0]   res_narrow,
  output logic [DW-1:0]   res_lo,
  output logic [DW-1:0]   res_hi
);
  import dwalu_pkg::*;

  localparam int LW  = 2 * DW;
  localparam int NSH = $clog2(DW);
  localparam int LSH = $clog2(LW);

  grp_e          grp;
  logic          sgn, take, n_we, p_we;
  logic [DW-1:0] n_val, nq, nr, nlog, nsh;
  logic [LW-1:0] p_val, wq, wr, wlog, wsh;
  logic [LW-1:0] ext_a, ext_b, lprod, wprod;
  logic          unused_shamt_hi;

  assign unused_shamt_hi = ^shamt[SAW-1:LSH];
  assign grp = decode(func, wide_sel);
  assign sgn = ~func[0];

  // Operands extended for the 32x32 long product.
  assign ext_a = {{DW{sgn & a_narrow[DW-1]}}, a_narrow};
  assign ext_b = {{DW{sgn & b_narrow[DW-1]}}, b_narrow};
  assign lprod = ext_a * ext_b;
  assign wprod = a_wide * b_wide;

  dwalu_divider #(.W(DW)) ndiv_i (
    .sgn(sgn), .num(a_narrow), .den(b_narrow), .quo(nq), .rem(nr)
  );
  dwalu_divider #(.W(LW)) wdiv_i (
    .sgn(sgn), .num(a_wide), .den(b_wide), .quo(wq), .rem(wr)
  );

  dwalu_bitops #(.W(DW)) nlog_i (
    .sel(func[2:0]), .x(a_narrow), .y(b_narrow), .r(nlog)
  );
  dwalu_bitops #(.W(LW)) wlog_i (
    .sel(func[2:0]), .x(a_wide), .y(b_wide), .r(wlog)
  );

  dwalu_shifter #(.W(DW), .AW(NSH)) nsh_i (
    .kind(func[1:0]), .x(a_narrow), .amt(shamt[NSH-1:0]), .r(nsh)
  );
  dwalu_shifter #(.W(LW), .AW(LSH)) wsh_i (
    .kind(func[1:0]), .x(a_wide), .amt(shamt[LSH-1:0]), .r(wsh)
  );

  always_comb begin
    n_val = '0;
    p_val = '0;
    case (grp)
      G_ADD:   begin n_val = a_narrow + b_narrow; p_val = a_wide + b_wide; end
      G_SUB:   begin n_val = a_narrow - b_narrow; p_val = a_wide - b_wide; end
      G_MUL:   begin n_val = lprod[DW-1:0];       p_val = wprod;           end
      G_DIV:   begin n_val = nq;                  p_val = wq;              end
      G_LOGIC: begin n_val = nlog;                p_val = wlog;            end
      G_SHIFT: begin n_val = nsh;                 p_val = wsh;             end
      G_LMUL:  p_val = lprod;
      G_LDIV:  p_val = {nr, nq};
      default: ;
    endcase
    take = op_valid && (grp != G_NONE);
    p_we = take && (wide_sel || grp == G_LMUL || grp == G_LDIV);
    n_we = take && !p_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_pair   <= 1'b0;
      res_narrow <= '0;
      res_lo     <= '0;
      res_hi     <= '0;
    end else begin
      out_valid <= take;
      out_pair  <= p_we;
      if (n_we) res_narrow <= n_val;
      if (p_we) {res_hi, res_lo} <= p_val;
    end
  end

  // wr is the wide remainder; only its quotient is architecturally used.
  logic unused_wide_rem;
  assign unused_wide_rem = ^wr;

endmodule

// File: rtl/dwalu_chk.sv
module dwalu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          wide_sel,
  input logic [5:0]    func,
  input logic [DW-1:0] a_narrow,
  input logic [DW-1:0] b_narrow,
  input logic          out_valid,
  input logic          out_pair,
  input logic [DW-1:0] res_narrow,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi
);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!out_valid && $stable(res_narrow) && $stable(res_lo) && $stable(res_hi)));

  // R2
  narrow_keeps_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_pair) |-> ($stable(res_lo) && $stable(res_hi)));

  // R8
  pair_keeps_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pair) |-> $stable(res_narrow));

  // R13
  pair_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_pair |-> out_valid);

  // R10
  divzero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !wide_sel && func == 6'd7 && b_narrow == '0) |=> (res_narrow == '1));

  // R6
  lmulu_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !wide_sel && func == 6'd17) |=>
      ({res_hi, res_lo} == $past({{DW{1'b0}}, a_narrow} * {{DW{1'b0}}, b_narrow})));
endmodule

bind dwalu dwalu_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .wide_sel(wide_sel), .func(func),
  .a_narrow(a_narrow), .b_narrow(b_narrow), .out_valid(out_valid),
  .out_pair(out_pair), .res_narrow(res_narrow), .res_lo(res_lo), .res_hi(res_hi)
);

// File: tb/dwalu_tb.sv
module dwalu_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, wide_sel;
  logic [5:0]  func;
  logic [31:0] a_narrow, b_narrow;
  logic [63:0] a_wide, b_wide;
  logic [9:0]  shamt;
  logic        out_valid, out_pair;
  logic [31:0] res_narrow, res_lo, res_hi;

  int checks = 0;
  int errors = 0;

  logic        exp_v, exp_p;
  logic [31:0] exp_n, exp_lo, exp_hi;
  logic [31:0] vals [8];
  logic [5:0]  codes [21];

  always #5 clk = ~clk;

  dwalu #(.DW(32), .SAW(10)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .wide_sel(wide_sel), .func(func),
    .a_narrow(a_narrow), .b_narrow(b_narrow), .a_wide(a_wide), .b_wide(b_wide),
    .shamt(shamt), .out_valid(out_valid), .out_pair(out_pair),
    .res_narrow(res_narrow), .res_lo(res_lo), .res_hi(res_hi)
  );

  function automatic logic [31:0] sq32(logic [31:0] x, logic [31:0] y);
    logic signed [31:0] sx, sy;
    sx = x; sy = y;
    if (y == 0) return 32'hFFFF_FFFF;
    if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return x;
    return sx / sy;
  endfunction

  function automatic logic [31:0] sr32(logic [31:0] x, logic [31:0] y);
    logic signed [31:0] sx, sy;
    sx = x; sy = y;
    if (y == 0) return x;
    if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 32'h0;
    return sx % sy;
  endfunction

  function automatic logic [63:0] sq64(logic [63:0] x, logic [63:0] y);
    logic signed [63:0] sx, sy;
    sx = x; sy = y;
    if (y == 0) return '1;
    if (x == 64'h8000_0000_0000_0000 && y == '1) return x;
    return sx / sy;
  endfunction

  task automatic check(input string tag, input logic [97:0] got, input logic [97:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Present one operation at a negedge, model it, and check one clock later.
  task automatic run_op(input logic v, input logic w, input logic [5:0] f,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] aw, input logic [63:0] bw,
                        input logic [9:0] s);
    logic [31:0] nv;
    logic [63:0] pv;
    logic        lg, tp;
    string       tg;
    logic signed [63:0] sp;
    nv = exp_n; pv = {exp_hi, exp_lo}; lg = 1'b1; tp = w;
    tg = w ? "R8" : "R2";
    case (f)
      6'd0, 6'd1: begin nv = a + b; pv = aw + bw; end
      6'd2, 6'd3: begin nv = a - b; pv = aw - bw; end
      6'd4, 6'd5: begin nv = a * b; pv = aw * bw; if (!w) tg = "R3"; end
      6'd6: begin nv = sq32(a, b); pv = sq64(aw, bw); if (!w) tg = "R3"; end
      6'd7: begin
        nv = (b == 0) ? 32'hFFFF_FFFF : a / b;
        pv = (bw == 0) ? '1 : aw / bw;
        if (!w) tg = "R3";
      end
      6'd8:  begin nv = a & b;    pv = aw & bw;    if (!w) tg = "R4"; end
      6'd9:  begin nv = a | b;    pv = aw | bw;    if (!w) tg = "R4"; end
      6'd10: begin nv = ~(a & b); pv = ~(aw & bw); if (!w) tg = "R4"; end
      6'd11: begin nv = ~(a | b); pv = ~(aw | bw); if (!w) tg = "R4"; end
      6'd12: begin nv = a ^ b;    pv = aw ^ bw;    if (!w) tg = "R4"; end
      6'd13: begin nv = ~(a ^ b); pv = ~(aw ^ bw); if (!w) tg = "R4"; end
      6'd16: if (w) lg = 1'b0; else begin
        sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        pv = sp; tp = 1'b1; tg = "R6/R13";
      end
      6'd17: if (w) lg = 1'b0; else begin
        pv = {32'h0, a} * {32'h0, b}; tp = 1'b1; tg = "R6/R13";
      end
      6'd18: if (w) lg = 1'b0; else begin
        pv = {sr32(a, b), sq32(a, b)}; tp = 1'b1; tg = "R7";
      end
      6'd19: if (w) lg = 1'b0; else begin
        pv = (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b}; tp = 1'b1; tg = "R7";
      end
      6'd24: begin nv = a << s[4:0]; pv = aw << s[5:0]; tg = w ? "R9" : "R5"; end
      6'd25: begin nv = a >> s[4:0]; pv = aw >> s[5:0]; tg = w ? "R9" : "R5"; end
      6'd26: begin
        nv = $signed(a) >>> s[4:0]; pv = $signed(aw) >>> s[5:0];
        tg = w ? "R9" : "R5";
      end
      default: lg = 1'b0;
    endcase
    if (!w && (f == 6 || f == 7 || f == 18 || f == 19) && b == 0) tg = "R10";
    if (w && (f == 6 || f == 7) && bw == 0) tg = "R10";
    if (!w && (f == 6 || f == 18) && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) tg = "R11";
    if (w && f == 6 && aw == 64'h8000_0000_0000_0000 && bw == '1) tg = "R11";
    if (!v || !lg) tg = "R12";
    exp_v = v && lg;
    exp_p = v && lg && tp;
    if (exp_v) begin
      if (tp) {exp_hi, exp_lo} = pv;
      else exp_n = nv;
    end
    op_valid = v; wide_sel = w; func = f;
    a_narrow = a; b_narrow = b; a_wide = aw; b_wide = bw; shamt = s;
    @(negedge clk);
    check(tg, {out_valid, out_pair, res_narrow, res_lo, res_hi},
              {exp_v, exp_p, exp_n, exp_lo, exp_hi});
  endtask

  initial begin
    vals = '{32'h0, 32'h1, 32'h3, 32'h7FFF_FFFF, 32'h8000_0000,
             32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFF9};
    for (int k = 0; k < 14; k++) codes[k] = 6'(k);
    for (int k = 0; k < 4; k++)  codes[14 + k] = 6'(16 + k);
    for (int k = 0; k < 3; k++)  codes[18 + k] = 6'(24 + k);

    rst = 1'b1; op_valid = 0; wide_sel = 0; func = 0;
    a_narrow = 0; b_narrow = 0; a_wide = 0; b_wide = 0; shamt = 0;
    exp_v = 0; exp_p = 0; exp_n = 0; exp_lo = 0; exp_hi = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", {out_valid, out_pair, res_narrow, res_lo, res_hi}, '0);

    // Corner-value sweep over every defined code at both widths
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 21; k++) begin
          run_op(1'b1, 1'b0, codes[k], vals[i], vals[j],
                 {vals[j], vals[i]}, {vals[i], vals[7-j]}, {4'b1101, 6'(i * 9 + j * 7)});
          run_op(1'b1, 1'b1, codes[k], vals[i], vals[j],
                 {vals[j], vals[i]}, {vals[i], vals[7-j]}, {4'b1101, 6'(i * 9 + j * 7)});
        end

    // Full shift-distance sweep, upper field bits set to show they are ignored (R5, R9)
    for (int s = 0; s < 64; s++)
      for (int k = 24; k < 27; k++) begin
        run_op(1'b1, 1'b0, 6'(k), 32'h8000_00F1, 32'h0, 64'h0, 64'h0, {4'b0110, 6'(s)});
        run_op(1'b1, 1'b1, 6'(k), 32'h0, 32'h0, 64'h8000_0000_0000_1234, 64'h0,
               {4'b1001, 6'(s)});
      end

    // Every code at both widths, with idle cycles between (R12)
    for (int f = 0; f < 64; f++) begin
      run_op(1'b1, 1'b0, 6'(f), 32'hA5A5_0F0F, 32'h0000_0013,
             64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0105, 10'd3);
      run_op(1'b0, 1'b0, 6'd0, 32'h1, 32'h1, 64'h1, 64'h1, 10'd0);
      run_op(1'b1, 1'b1, 6'(f), 32'h5A5A_F0F0, 32'h0000_0007,
             64'hFEDC_BA98_7654_3210, 64'h0000_0001_0000_0003, 10'd5);
      run_op(1'b0, 1'b1, 6'd2, 32'h1, 32'h1, 64'h1, 64'h1, 10'd0);
    end

    // Directed divide corners: zero divisor (R10) and signed overflow (R11)
    run_op(1'b1, 1'b1, 6'd6, 32'h0, 32'h0, 64'h0000_0123_0000_0456, 64'h0, 10'd0);
    run_op(1'b1, 1'b1, 6'd7, 32'h0, 32'h0, 64'hFFFF_0000_1111_2222, 64'h0, 10'd0);
    run_op(1'b1, 1'b1, 6'd6, 32'h0, 32'h0, 64'h8000_0000_0000_0000, '1, 10'd0);
    run_op(1'b1, 1'b0, 6'd18, 32'h8000_0000, 32'hFFFF_FFFF, 64'h0, 64'h0, 10'd0);
    run_op(1'b1, 1'b0, 6'd19, 32'hDEAD_BEEF, 32'h0, 64'h0, 64'h0, 10'd0);
    run_op(1'b1, 1'b0, 6'd18, 32'hFFFF_FFF9, 32'h2, 64'h0, 64'h0, 10'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule